// File: doc/BRIEF.md
# Run-Time Selectable Delay Line

This block is a serial-in, serial-out shift register with sixteen stages per lane. The stage that drives the output is picked at run time through a select input. It lets a designer match the latency of a short datapath branch to a longer one without rebuilding the logic. New data enters at stage 0 on each clock edge where the enable is high. A select value `d` returns the bit that entered `d+1` enabled cycles earlier. Changing the select takes effect within the same cycle.

The last stage is also brought out on its own port, so several instances can be chained to build longer delays. An extra output flip-flop gives a timing-friendly copy of the tapped bit that is one enabled cycle later. A parameter replicates the structure across several independent lanes. The stored bits are never cleared. The synchronous reset clears only the output flip-flop.

Top module: `tap_delay_line`

## Requirements
- R1: On every rising clock edge with `ce` high, stage 0 captures `din` and each stage k>0 takes the old value of stage k-1. With `tap_sel` = 0, `tap_out` equals the `din` sampled at the most recent enabled edge.
- R2: For any `tap_sel` value d from 0 to 15, `tap_out` equals the `din` sampled d+1 enabled edges earlier. Edges with `ce` low do not count.
- R3: On edges with `ce` low, the stored stages hold their values, and so do `cascade_out` and `tap_q`, whatever `din` does.
- R4: `tap_out` follows a change of `tap_sel` combinationally within the same cycle, with no clock edge in between.
- R5: `cascade_out` always shows the last stage (index 15), which is the `din` sampled 16 enabled edges earlier.
- R6: On an enabled edge, `tap_q` loads the `tap_out` value present just before that edge. This gives one further enabled cycle of delay.
- R7: A synchronous, active-high `rst` forces `tap_q` to all zeros at the next edge, and this takes priority over `ce`. The stored stages are not touched.
- R8: Each lane bit i of `din` is delayed only into bit i of `tap_out`, `tap_q` and `cascade_out`. Lanes share `ce` and `tap_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output flip-flop |
| ce | input | 1 | Shift enable |
| din | input | LANES | Serial data, one bit per lane |
| tap_sel | input | SEL_W | Stage index that drives the tap |
| tap_out | output | LANES | Combinational bit from the selected stage |
| tap_q | output | LANES | Registered copy of the tap |
| cascade_out | output | LANES | Last stage, for chaining instances |

## Verification
The bench first shifts sixteen known bits in, since the contents are undefined at power-up. It then walks a vector table that mixes enabled and stalled cycles, alternating lane patterns and select values across the whole range. Stalled cycles with a changing `din` separate true holding from a shift that ignores `ce`. Different bits on the two lanes expose lanes that are crossed or merged. Sweeping every select value between two edges shows whether the tap is combinational and whether each index maps to the right stage. A reset in the middle of a run, followed by a sweep, checks that only the output flip-flop is cleared.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;

    localparam int unsigned DEF_STAGES = 16;
    localparam int unsigned DEF_LANES  = 2;

    function automatic int unsigned sel_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic bit sel_in_range(input int unsigned idx, input int unsigned n);
        return idx < n;
    endfunction

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

endpackage

// File: rtl/tap_delay_chain.sv
module tap_delay_chain
    import tap_delay_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES,
    parameter int unsigned LANES  = DEF_LANES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ce,
    input  logic [LANES-1:0]               din,
    output logic [STAGES-1:0][LANES-1:0]   stages
);

    always_ff @(posedge clk) begin
        if (ce) stages[0] <= din;
    end

    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (ce) stages[k] <= stages[k-1];
            end

            a_r1_shift_link: assert property (@(posedge clk) disable iff (rst)
                ce |=> stages[k] == $past(stages[k-1]));
        end
    endgenerate

    a_r1_entry: assert property (@(posedge clk) disable iff (rst)
        ce |=> stages[0] == $past(din));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(stages));

endmodule

// File: rtl/tap_delay_mux.sv
module tap_delay_mux
    import tap_delay_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES,
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned SEL_W  = sel_bits(STAGES)
) (
    input  logic [STAGES-1:0][LANES-1:0]   stages,
    input  logic [SEL_W-1:0]               sel,
    output logic [LANES-1:0]               tap
);

    localparam int unsigned LAST = STAGES - 1;

    always_comb begin
        if (sel_in_range(int'(sel), STAGES)) tap = stages[sel];
        else                                 tap = stages[LAST];
    end

endmodule

// File: rtl/tap_delay_out.sv
module tap_delay_out
    import tap_delay_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter out_mode_e   MODE  = OUT_REG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [LANES-1:0] tap,
    output logic [LANES-1:0] tap_q
);

    generate
        if (MODE == OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)     tap_q <= '0;
                else if (ce) tap_q <= tap;
            end

            a_r6_load: assert property (@(posedge clk) disable iff (rst)
                ce |=> tap_q == $past(tap));

            a_r7_clear: assert property (@(posedge clk)
                rst |=> tap_q == '0);
        end else begin : g_comb
            assign tap_q = tap;
        end
    endgenerate

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
    import tap_delay_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES,
    parameter int unsigned LANES  = DEF_LANES,
    parameter out_mode_e   MODE   = OUT_REG,
    parameter int unsigned SEL_W  = sel_bits(STAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [LANES-1:0] din,
    input  logic [SEL_W-1:0] tap_sel,
    output logic [LANES-1:0] tap_out,
    output logic [LANES-1:0] tap_q,
    output logic [LANES-1:0] cascade_out
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][LANES-1:0] stages;

    tap_delay_chain #(.STAGES(STAGES), .LANES(LANES)) chain_i (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .stages(stages)
    );

    tap_delay_mux #(.STAGES(STAGES), .LANES(LANES), .SEL_W(SEL_W)) mux_i (
        .stages(stages), .sel(tap_sel), .tap(tap_out)
    );

    tap_delay_out #(.LANES(LANES), .MODE(MODE)) out_i (
        .clk(clk), .rst(rst), .ce(ce), .tap(tap_out), .tap_q(tap_q)
    );

    assign cascade_out = stages[LAST];

    a_r5_cascade: assert property (@(posedge clk) disable iff (rst)
        ce |=> cascade_out == $past(stages[LAST-1]));

    a_r3_cascade_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(cascade_out));

endmodule

// File: tb/tap_delay_line_tb.sv
module tap_delay_line_tb_top;

    localparam int CLK_PERIOD = 40;
    localparam int N  = 16;
    localparam int L  = 2;
    localparam int NV = 24;

    // vector: {ce, din[1:0], sel[3:0]}
    localparam logic [6:0] VEC [NV] = '{
        7'b1_01_0000, 7'b1_10_0001, 7'b0_11_0010, 7'b0_00_0011,
        7'b1_11_1111, 7'b1_00_0111, 7'b1_01_1000, 7'b0_10_0000,
        7'b1_10_0101, 7'b1_11_1110, 7'b0_01_1111, 7'b1_00_0010,
        7'b1_01_1100, 7'b1_10_0100, 7'b1_11_1001, 7'b0_00_0110,
        7'b0_11_0001, 7'b1_01_1101, 7'b1_00_1011, 7'b1_10_1111,
        7'b1_11_0000, 7'b0_10_1010, 7'b1_01_0011, 7'b1_00_1110
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ce  = 1'b0;
    logic [L-1:0] din = '0;
    logic [3:0]   tap_sel = '0;
    logic [L-1:0] tap_out, tap_q, cascade_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [L-1:0] hist [N];
    bit           hv   [N];
    logic [L-1:0] qm;
    bit           qv;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_delay_line dut_i (
        .clk(clk), .rst(rst), .ce(ce), .din(din), .tap_sel(tap_sel),
        .tap_out(tap_out), .tap_q(tap_q), .cascade_out(cascade_out)
    );

    task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit c, input logic [L-1:0] d, input logic [3:0] s);
        @(negedge clk);
        ce = c; din = d; tap_sel = s;
        #1;
        if (hv[s]) check((s == 0) ? "R1 tap" : "R2 tap", tap_out, hist[s]);
        if (hv[N-1]) check("R5 cascade", cascade_out, hist[N-1]);
        if (qv) check(c ? "R6 tap_q" : "R3 tap_q", tap_q, qm);
        @(posedge clk);
        if (c) begin
            qm = hist[s]; qv = hv[s];
            for (int k = N-1; k > 0; k--) begin
                hist[k] = hist[k-1]; hv[k] = hv[k-1];
            end
            hist[0] = d; hv[0] = 1'b1;
        end
    endtask

    task automatic sweep(input string req);
        @(negedge clk);
        ce = 1'b0;
        for (int s = 0; s < N; s++) begin
            tap_sel = 4'(s);
            #1;
            check(req, tap_out, hist[s]);
        end
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin hist[k] = '0; hv[k] = 1'b0; end
        qm = '0; qv = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 reset tap_q", tap_q, '0);
        rst = 1'b0;
        qv = 1'b1;

        // fill with a known pattern
        for (int i = 0; i < N; i++) step(1'b1, 2'(i ^ (i >> 1)), 4'd0);

        // R4 R2: every stage read within one cycle
        sweep("R4 sweep");

        // table walk
        for (int v = 0; v < NV; v++) step(VEC[v][6], VEC[v][5:4], VEC[v][3:0]);

        // R3: long stall with toggling input
        for (int i = 0; i < 5; i++) step(1'b0, 2'(i), 4'(i * 3));
        sweep("R3 stall sweep");

        // R8: lanes carry opposite bits
        for (int i = 0; i < N; i++) step(1'b1, (i % 3 == 0) ? 2'b01 : 2'b10, 4'(N-1-i));
        sweep("R8 lane sweep");
        check("R8 cascade lane0", cascade_out, hist[N-1]);

        // R7: mid-run reset clears only tap_q
        @(negedge clk);
        rst = 1'b1; ce = 1'b1; din = 2'b11;
        @(posedge clk);
        for (int k = N-1; k > 0; k--) begin hist[k] = hist[k-1]; hv[k] = hv[k-1]; end
        hist[0] = 2'b11;
        @(negedge clk);
        rst = 1'b0; ce = 1'b0;
        #1;
        check("R7 tap_q cleared", tap_q, '0);
        qm = '0;
        sweep("R7 contents kept");

        // R6: registered output after reset
        step(1'b1, 2'b01, 4'd2);
        step(1'b1, 2'b10, 4'd7);
        step(1'b0, 2'b00, 4'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule